// File: doc/BRIEF.md
# Serial ADC readout sequencer

This block is the host-side master for an 8-bit successive-approximation converter that reports its results over a three-wire serial link: a bit clock, an active-low select and a single data line back from the converter. It makes the bit clock from the system clock with a fixed divider, opens a frame by pulling select low, and shifts in one sample on the rising bit-clock edges. The 8-bit result comes out with a one-cycle valid strobe. Alongside it is a flag that reports whether any of the zero bits around the data read back as one.

Frames start on a single-cycle request or, while a continuous-mode input is held, back to back at the fastest rate allowed. Two run-time settings set that rate. One is the total frame length in bit-clock periods, used as the minimum spacing between select falls. The other is the number of system cycles the converter needs to re-acquire its input, counted from the 13th rising bit-clock edge of the frame. A busy output covers the frame and both waits.

Top module: `adcrd_ctrl`

## Requirements
- R1: After reset, select is high, the bit clock is high, busy is low and the valid strobe is low.
- R2: When idle and not busy, a one-cycle start pulse (or a held continuous-mode input) pulls select low at the next clock edge. The bit clock stays high whenever select is high.
- R3: While select is low, the bit clock spends HALF_DIV system cycles high, then HALF_DIV low, and repeats. Its first falling edge comes HALF_DIV cycles after select falls. Select rises on the 16th rising edge, so it stays low for 32*HALF_DIV cycles.
- R4: The data line is sampled on every rising bit-clock edge. The values taken at rising edges 4 to 11 form the result, MSB first. The result and a one-cycle valid pulse appear in the same cycle that select rises.
- R5: The framing-error flag, presented with valid, is 1 if any sample from rising edges 1-3 or 12-15 was 1. The sample from rising edge 16 is ignored.
- R6: Consecutive select falls are spaced by the largest of three values: 2*HALF_DIV*F system cycles, where F is the frame-length setting clamped to 16..32; the acquisition setting plus 26*HALF_DIV cycles (the time from select fall to the 13th rising edge); and 32*HALF_DIV+1 cycles.
- R7: Busy goes high when select falls. It stays high until the frame has ended, the frame spacing has run out and the acquisition wait after the 13th rising edge has run out.
- R8: A start pulse that arrives while busy is high is dropped. It does not produce a later frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Single-cycle conversion request |
| cont_i | input | 1 | Continuous mode: start a frame as soon as allowed |
| cfg_frame_sclks_i | input | 6 | Frame length in bit-clock periods, clamped to 16..32 |
| cfg_acq_cycles_i | input | ACQ_W | Acquisition wait in system cycles after the 13th rising edge |
| ser_dat_i | input | 1 | Serial data from the converter |
| ser_clk_o | output | 1 | Bit clock to the converter |
| sel_n_o | output | 1 | Active-low converter select |
| busy_o | output | 1 | Frame or pacing wait in progress |
| rd_valid_o | output | 1 | One-cycle result strobe |
| rd_data_o | output | 8 | Recovered sample |
| frm_err_o | output | 1 | A framing zero read back as one |

## Verification
A wrong phase or half-period count moves the first falling edge and the select-low length off 2 and 64 cycles within a single frame. If the shift register is mis-indexed, the recovered byte in that same frame comes back rotated or bit-swapped, or the error flag is wrong for a pattern with a single one in a framing position. A pacing counter that loads the wrong value, or never runs out, shows up as a wrong select-fall spacing in continuous mode from the second frame on. It also shows up as a wrong cycle count at the falling edge of busy, or as an extra frame after a start pulse that should have been dropped.

// File: rtl/adcrd_pkg.sv
// Shared constants and types for the serial ADC readout sequencer.
// Assumes the fixed frame layout: 3 leading zeros, 8 data bits, 4 trailing zeros.
package adcrd_pkg;
    localparam int unsigned XFER_RISES = 16;  // rising edges per frame
    localparam int unsigned LEAD_BITS  = 3;
    localparam int unsigned DATA_BITS  = 8;
    localparam int unsigned TRAIL_BITS = 4;
    localparam int unsigned HOLD_RISE  = 13;  // acquisition starts here
    localparam int unsigned MIN_FRAME  = 16;
    localparam int unsigned MAX_FRAME  = 32;

    typedef enum logic {
        ST_IDLE  = 1'b0,
        ST_FRAME = 1'b1
    } seq_state_t;
endpackage

// File: rtl/adcrd_sclk_gen.sv
// Bit-clock generator: while run is high, toggles the bit clock every HALF_DIV
// system cycles, starting with a high phase. It flags each rising edge and
// numbers it from 1.
// Assumes run drops only right after a rising edge, while the clock is high.
module adcrd_sclk_gen #(
    parameter int unsigned HALF_DIV = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       run,
    output logic       sclk,
    output logic       rise_stb,
    output logic [4:0] rise_num
);
    localparam int unsigned PW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
    localparam logic [PW-1:0] PH_LAST = PW'(HALF_DIV - 1);

    logic [PW-1:0] phase;
    logic [4:0]    half_idx;
    logic          half_end;

    assign half_end = run && (phase == PH_LAST);
    assign rise_stb = half_end && half_idx[0];
    assign rise_num = {1'b0, half_idx[4:1]} + 5'd1;

    // Phase counter, half-period index and bit-clock level.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            phase    <= '0;
            half_idx <= '0;
            sclk     <= 1'b1;
        end else if (half_end) begin
            phase    <= '0;
            half_idx <= half_idx + 5'd1;
            sclk     <= ~sclk;
        end else begin
            phase    <= phase + 1'b1;
        end
    end

    // R3: the bit clock only moves at the end of a half period
    p_sclk_steady_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !half_end) |=> $stable(sclk));
endmodule

// File: rtl/adcrd_capture.sv
// Capture path: shifts the data line in on rising edges 1..15. On edge 16 it
// presents the data byte and the framing check with a one-cycle valid pulse.
// Assumes 15 shifts always happen before the last-edge strobe in a frame.
module adcrd_capture
    import adcrd_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 sdata,
    input  logic                 shift_stb,
    input  logic                 last_stb,
    output logic                 rd_valid,
    output logic [DATA_BITS-1:0] rd_data,
    output logic                 frm_err
);
    localparam int unsigned SHW = LEAD_BITS + DATA_BITS + TRAIL_BITS;

    logic [SHW-1:0] shreg;

    // Bit shift register and result registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shreg    <= '0;
            rd_valid <= 1'b0;
            rd_data  <= '0;
            frm_err  <= 1'b0;
        end else begin
            rd_valid <= 1'b0;
            if (shift_stb) begin
                shreg <= {shreg[SHW-2:0], sdata};
            end
            if (last_stb) begin
                rd_valid <= 1'b1;
                rd_data  <= shreg[TRAIL_BITS+DATA_BITS-1:TRAIL_BITS];
                frm_err  <= (|shreg[SHW-1:SHW-LEAD_BITS]) | (|shreg[TRAIL_BITS-1:0]);
            end
        end
    end

    // R4: the result strobe lasts one cycle
    p_valid_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |=> !rd_valid);
endmodule

// File: rtl/adcrd_pacer.sv
// Pacing timers: a frame-spacing counter loaded at each select fall and an
// acquisition counter loaded at the 13th rising edge. clear is high when both
// have run out.
// Assumes launch is only raised while clear is high.
module adcrd_pacer
    import adcrd_pkg::*;
#(
    parameter int unsigned HALF_DIV = 2,
    parameter int unsigned ACQ_W    = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             launch,
    input  logic             mark_hold_end,
    input  logic [5:0]       cfg_frame_sclks,
    input  logic [ACQ_W-1:0] cfg_acq_cycles,
    output logic             clear
);
    localparam int unsigned FCW = $clog2(2 * MAX_FRAME * HALF_DIV + 1);

    logic [5:0]       frame_eff;
    logic [FCW-1:0]   period;
    logic [FCW-1:0]   frame_cnt;
    logic [ACQ_W-1:0] acq_cnt;

    // Clamp the frame length to the legal range.
    always_comb begin
        if (cfg_frame_sclks < 6'(MIN_FRAME))      frame_eff = 6'(MIN_FRAME);
        else if (cfg_frame_sclks > 6'(MAX_FRAME)) frame_eff = 6'(MAX_FRAME);
        else                                      frame_eff = cfg_frame_sclks;
    end

    assign period = FCW'(32'(frame_eff) * (2 * HALF_DIV));
    assign clear  = (frame_cnt == '0) && (acq_cnt == '0);

    // Frame-spacing countdown from the select fall.
    always_ff @(posedge clk) begin
        if (!rst_n)                 frame_cnt <= '0;
        else if (launch)            frame_cnt <= period - 1'b1;
        else if (frame_cnt != '0)   frame_cnt <= frame_cnt - 1'b1;
    end

    // Acquisition countdown from the 13th rising edge.
    always_ff @(posedge clk) begin
        if (!rst_n)                 acq_cnt <= '0;
        else if (mark_hold_end)     acq_cnt <= (cfg_acq_cycles == '0) ? '0 : cfg_acq_cycles - 1'b1;
        else if (acq_cnt != '0)     acq_cnt <= acq_cnt - 1'b1;
    end

    // R6: no new frame while the spacing counter is running
    p_frame_gap_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_cnt != '0) |=> (frame_cnt == $past(frame_cnt) - 1'b1));
    // R6: no new hold phase while the acquisition wait is running
    p_acq_gap_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (acq_cnt != '0) |=> (acq_cnt == $past(acq_cnt) - 1'b1));
endmodule

// File: rtl/adcrd_ctrl.sv
// Serial ADC readout sequencer top. Accepts a start request or continuous
// mode, runs one select-low frame of 16 bit-clock periods, returns the
// sample and paces the next frame.
// Assumes the converter's data line is synchronous to clk, with ample setup.
module adcrd_ctrl
    import adcrd_pkg::*;
#(
    parameter int unsigned HALF_DIV = 2,
    parameter int unsigned ACQ_W    = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             cont_i,
    input  logic [5:0]       cfg_frame_sclks_i,
    input  logic [ACQ_W-1:0] cfg_acq_cycles_i,
    input  logic             ser_dat_i,
    output logic             ser_clk_o,
    output logic             sel_n_o,
    output logic             busy_o,
    output logic             rd_valid_o,
    output logic [7:0]       rd_data_o,
    output logic             frm_err_o
);
    seq_state_t state;
    logic       run;
    logic       accept;
    logic       clear;
    logic       rise_stb;
    logic [4:0] rise_num;
    logic       last_stb;
    logic       shift_stb;
    logic       mark13;

    assign run       = (state == ST_FRAME);
    assign accept    = (state == ST_IDLE) && (start_i || cont_i) && clear;
    assign last_stb  = rise_stb && (rise_num == 5'(XFER_RISES));
    assign shift_stb = rise_stb && (rise_num != 5'(XFER_RISES));
    assign mark13    = rise_stb && (rise_num == 5'(HOLD_RISE));
    assign sel_n_o   = !run;
    assign busy_o    = run || !clear;

    // Frame sequencer: idle until accepted, frame until the last rising edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            case (state)
                ST_IDLE:  if (accept)   state <= ST_FRAME;
                ST_FRAME: if (last_stb) state <= ST_IDLE;
                default:                state <= ST_IDLE;
            endcase
        end
    end

    adcrd_sclk_gen #(.HALF_DIV(HALF_DIV)) u_sclk (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (run),
        .sclk     (ser_clk_o),
        .rise_stb (rise_stb),
        .rise_num (rise_num)
    );

    adcrd_capture u_cap (
        .clk       (clk),
        .rst_n     (rst_n),
        .sdata     (ser_dat_i),
        .shift_stb (shift_stb),
        .last_stb  (last_stb),
        .rd_valid  (rd_valid_o),
        .rd_data   (rd_data_o),
        .frm_err   (frm_err_o)
    );

    adcrd_pacer #(.HALF_DIV(HALF_DIV), .ACQ_W(ACQ_W)) u_pace (
        .clk             (clk),
        .rst_n           (rst_n),
        .launch          (accept),
        .mark_hold_end   (mark13),
        .cfg_frame_sclks (cfg_frame_sclks_i),
        .cfg_acq_cycles  (cfg_acq_cycles_i),
        .clear           (clear)
    );

    // R2: the bit clock idles high while select is high
    p_clk_idle_high_r2: assert property (@(posedge clk) disable iff (!rst_n)
        sel_n_o |-> ser_clk_o);
    // R7: busy covers the whole select-low window
    p_busy_in_frame_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !sel_n_o |-> busy_o);
    // R4: the result appears exactly as select rises
    p_valid_at_end_r4: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid_o |-> $rose(sel_n_o));
endmodule

// File: tb/test_adcrd_ctrl.sv
`timescale 1ns/1ps
// Directed bench for the serial ADC readout sequencer, with a behavioural
// converter model that drives bit k of a 16-bit pattern after the k-th
// falling bit-clock edge.
module test_adcrd_ctrl;
    localparam int HALF = 2;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start_i = 1'b0;
    logic       cont_i = 1'b0;
    logic [5:0] cfg_frame = 6'd20;
    logic [7:0] cfg_acq = 8'd20;
    logic       ser_dat = 1'b0;
    logic       ser_clk, sel_n, busy, rd_valid, frm_err;
    logic [7:0] rd_data;

    int nchk = 0;
    int nfail = 0;

    adcrd_ctrl #(.HALF_DIV(HALF), .ACQ_W(8)) i_adcrd_ctrl (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .cont_i(cont_i),
        .cfg_frame_sclks_i(cfg_frame), .cfg_acq_cycles_i(cfg_acq),
        .ser_dat_i(ser_dat), .ser_clk_o(ser_clk), .sel_n_o(sel_n),
        .busy_o(busy), .rd_valid_o(rd_valid), .rd_data_o(rd_data),
        .frm_err_o(frm_err)
    );

    always #2 clk = ~clk;

    // Converter model: bit for rising edge k is pat[16-k].
    logic [15:0] pat = 16'h0;
    int fcnt = 0;
    always @(negedge sel_n) begin
        fcnt = 0;
        ser_dat <= 1'b0;
    end
    always @(negedge ser_clk) begin
        if (!sel_n) begin
            fcnt = fcnt + 1;
            if (fcnt <= 16) ser_dat <= pat[16 - fcnt];
        end
    end

    // Port monitor sampled away from the active edge.
    int cyc = 0, fall_cyc = 0, nfall = 0, spacing = 0, low_len = 0;
    int rises = 0, first_off = -1, nvalid = 0, busy_end = 0;
    logic [7:0] got_data = 8'h0;
    logic got_err = 1'b0, valid_sel = 1'b0;
    logic prev_sel = 1'b1, prev_clk = 1'b1, prev_busy = 1'b0;
    always @(negedge clk) begin
        cyc = cyc + 1;
        if (prev_sel && !sel_n) begin
            spacing = cyc - fall_cyc; fall_cyc = cyc; nfall = nfall + 1;
            rises = 0; first_off = -1;
        end
        if (!prev_sel && sel_n) low_len = cyc - fall_cyc;
        if (!prev_clk && ser_clk && !prev_sel) rises = rises + 1;
        if (prev_clk && !ser_clk && !sel_n && first_off < 0) first_off = cyc - fall_cyc;
        if (prev_busy && !busy) busy_end = cyc - fall_cyc;
        if (rd_valid) begin
            nvalid = nvalid + 1; got_data = rd_data; got_err = frm_err; valid_sel = sel_n;
        end
        prev_sel = sel_n; prev_clk = ser_clk; prev_busy = busy;
    end

    task automatic chk(string req, string what, int act, int exp);
        nchk++;
        if (act != exp) begin
            nfail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic pulse_start();
        @(posedge clk) #1 start_i = 1'b1;
        @(posedge clk) #1 start_i = 1'b0;
    endtask

    task automatic wait_idle();
        while (busy) @(posedge clk);
        repeat (4) @(posedge clk);
    endtask

    // R1: reset state at the ports
    task automatic t_reset();
        repeat (3) @(posedge clk);
        #1;
        chk("R1", "select", int'(sel_n), 1);
        chk("R1", "bit clock", int'(ser_clk), 1);
        chk("R1", "busy", int'(busy), 0);
        chk("R1", "valid", int'(rd_valid), 0);
        @(posedge clk) #1 rst_n = 1'b1;
        repeat (3) @(posedge clk);
    endtask

    // R2 R3 R4 R5 R7: one requested frame with a given pattern
    task automatic t_single(logic [15:0] p, int exp_busy_end);
        int n0;
        logic [7:0] exp_d;
        logic exp_e;
        n0 = nvalid;
        pat = p;
        exp_d = p[12:5];
        exp_e = (|p[15:13]) | (|p[4:1]);
        pulse_start();
        chk("R2", "select low after start", int'(sel_n), 0);
        chk("R2", "clock high at select fall", int'(ser_clk), 1);
        chk("R7", "busy at select fall", int'(busy), 1);
        while (nvalid == n0) @(posedge clk);
        chk("R3", "first fall offset", first_off, HALF);
        chk("R3", "select low length", low_len, 32 * HALF);
        chk("R3", "rising edges", rises, 16);
        chk("R4", "data", int'(got_data), int'(exp_d));
        chk("R4", "select high at valid", int'(valid_sel), 1);
        chk("R5", "framing flag", int'(got_err), int'(exp_e));
        wait_idle();
        chk("R4", "valid pulses", nvalid - n0, 1);
        chk("R7", "busy end offset", busy_end, exp_busy_end);
    endtask

    // R6: continuous mode spacing between select falls
    task automatic t_cont(int f, int a, int exp_sp);
        int f0;
        cfg_frame = 6'(f);
        cfg_acq = 8'(a);
        pat = 16'h0B60;
        f0 = nfall;
        @(posedge clk) #1 cont_i = 1'b1;
        while (nfall < f0 + 3) @(posedge clk);
        #1 cont_i = 1'b0;
        chk("R6", $sformatf("spacing F=%0d A=%0d", f, a), spacing, exp_sp);
        wait_idle();
        chk("R4", "data in continuous mode", int'(got_data), 8'h5B);
    endtask

    // R8: starts while busy are dropped
    task automatic t_ignore();
        int f0;
        cfg_frame = 6'd20;
        cfg_acq = 8'd60;
        f0 = nfall;
        pulse_start();
        repeat (20) @(posedge clk);
        pulse_start();
        while (!sel_n) @(posedge clk);
        repeat (10) @(posedge clk);
        chk("R8", "busy after frame", int'(busy), 1);
        pulse_start();
        repeat (300) @(posedge clk);
        chk("R8", "frames started", nfall - f0, 1);
    endtask

    initial begin
        #(4 * 150000);
        nfail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nchk + 1, nfail);
        $finish;
    end

    initial begin
        t_reset();
        // F=20, A=20: busy ends at max(79, 71, 64)
        t_single(16'h14A0, 79);   // data A5, clean framing
        t_single(16'h1FE0, 79);   // data FF
        t_single(16'h94A0, 79);   // R5 leading one
        t_single(16'h0002, 79);   // R5 trailing one at edge 15
        t_single(16'h0001, 79);   // R5 edge 16 ignored
        t_cont(20, 20, 80);
        t_cont(20, 60, 112);
        t_cont(16, 0, 65);
        t_cont(40, 0, 128);       // clamped to 32
        t_cont(5, 0, 65);         // clamped to 16
        t_ignore();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nchk, nfail);
        $finish;
    end
endmodule